// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block sits between an on-chip requester and an external asynchronous NOR-style flash bus. The requester hands it one operation at a time: read a byte, program a byte, erase one sector, or erase a whole chip. The block turns each operation into the correct series of bus write cycles, including the unlock preamble. It times every strobe in system clocks from picosecond minimums given as parameters, rounding up.

After a program or erase command, it keeps reading the target location. It stops when the top data bit shows the final value rather than its inverse. If the device never settles within a set number of reads, the block sends the reset-to-read command and reports an error. The upper request address bits choose which of several chip selects is driven. At most one chip select is ever active, so two devices sharing a byte lane never drive it together.

Top module: `flash_cmd_seq`

## Requirements
- R1: A program request (op code 1) produces exactly four bus writes on the selected chip, in this order: AAh at 5555h, 55h at 2AAAh, A0h at 5555h, then the request data at the request offset.
- R2: A sector erase request (op code 2) produces six writes: AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then 30h at the request offset.
- R3: A chip erase request (op code 3) produces the same first five writes as R2, and its sixth write is 10h at 5555h.
- R4: Write enable stays low for at least ceil(max(T_WP, T_AH, T_DS)/T_CLK) clocks. Between pulses it stays high for at least ceil(T_WPH/T_CLK) clocks. Successive falling edges are at least ceil(T_WC/T_CLK) clocks apart. Address and write data do not change while write enable is low.
- R5: In a read cycle, output enable stays high with the chip selected for at least ceil(T_OEH/T_CLK) clocks before it falls. It then stays low for at least ceil(T_ACC/T_CLK) clocks. The host never drives the data bus while output enable is low, and output enable and write enable are never low together.
- R6: After the command writes, the block reads the request offset until data bit 7 equals the programmed bit 7 (program) or 1 (either erase). It then responds with error 0 and the last value read.
- R7: If POLL_LIMIT reads in a row all mismatch, the block issues one write of F0h at the request offset and responds with error 1 and the last value read.
- R8: The chip index is req_addr[HA_W-1:ADDR_W], and every cycle of a request asserts only flash_ce_n[index]. No two chip selects are ever low together. All chip selects are high while the block is idle.
- R9: req_ready is high only when idle, and a request is taken when req_valid and req_ready are both high. Each accepted request gives exactly one rsp_valid pulse, after which req_ready is high. Out of reset, req_ready=1, rsp_valid=0, flash_dq_oe=0, and all strobes are high.
- R10: A read request (op code 0) makes exactly one read cycle and no write, and responds with error 0 and the byte on the bus at the end of the output-enable-low window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_op | input | 2 | 0 read, 1 program, 2 sector erase, 3 chip erase |
| req_addr | input | HA_W | Chip index in upper bits, device offset in lower ADDR_W bits |
| req_wdata | input | 8 | Byte to program |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_err | output | 1 | Polling timed out |
| rsp_data | output | 8 | Read data or last polled value |
| flash_addr | output | ADDR_W | Device address |
| flash_dq_in | input | 8 | Data from the device |
| flash_dq_out | output | 8 | Data to the device |
| flash_dq_oe | output | 1 | Host drives the data bus |
| flash_ce_n | output | NUM_CS | Active-low chip selects |
| flash_oe_n | output | 1 | Active-low output enable |
| flash_we_n | output | 1 | Active-low write enable |

## Verification
The bench runs each operation type on every chip select against a device model. The model's reported busy count is varied, so the bench can tell an immediate match, a completion after several reads, a completion on exactly the last allowed read, and a timeout one read later. Programmed bytes with bit 7 set and bit 7 clear check that the block compares against the right expected bit rather than a fixed value. Random offsets and data, mixed with these directed cases, show any error in command order, in target addressing, or in chip select steering.

// File: rtl/fcs_pkg.sv
// Shared definitions for the flash command sequencer: operation codes,
// command bytes, unlock addresses and the time-to-clock conversion.
package fcs_pkg;

    typedef enum logic [1:0] {
        OP_READ       = 2'd0,
        OP_PROG       = 2'd1,
        OP_ERASE_SEC  = 2'd2,
        OP_ERASE_CHIP = 2'd3
    } fcs_op_e;

    localparam logic [7:0]  CMD_KEY1     = 8'hAA;
    localparam logic [7:0]  CMD_KEY2     = 8'h55;
    localparam logic [7:0]  CMD_PROGRAM  = 8'hA0;
    localparam logic [7:0]  CMD_ERASE    = 8'h80;
    localparam logic [7:0]  CMD_SECTOR   = 8'h30;
    localparam logic [7:0]  CMD_WHOLE    = 8'h10;
    localparam logic [7:0]  CMD_TO_READ  = 8'hF0;
    localparam logic [15:0] KEY_ADDR1    = 16'h5555;
    localparam logic [15:0] KEY_ADDR2    = 16'h2AAA;

    // Round a picosecond minimum up to whole clocks, never below one.
    function automatic int ps_to_cyc(input int t_ps, input int clk_ps);
        int c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fcs_cs_decode.sv
// Chip select steering. Turns a chip index plus an "active" flag into
// active-low one-hot selects. Assumes the index is held stable by the
// bus engine for the whole cycle; an index beyond NUM_CS selects nothing.
module fcs_cs_decode #(
    parameter int NUM_CS = 4,
    parameter int CS_W   = 2
) (
    input  logic              active,
    input  logic [CS_W-1:0]   sel,
    output logic [NUM_CS-1:0] ce_n
);

    for (genvar g = 0; g < NUM_CS; g++) begin : g_sel
        // One comparator per select line.
        assign ce_n[g] = !(active && (sel == CS_W'(g)));
    end

endmodule

// File: rtl/fcs_bus_engine.sv
// Executes one flash bus cycle per start pulse: a timed write (setup,
// write-enable low, write-enable high) or a timed read (output-enable
// high setup, output-enable low access, sample). All strobes are
// registered. Assumes start is only raised while the engine is idle.
module fcs_bus_engine #(
    parameter int ADDR_W    = 21,
    parameter int CS_W      = 2,
    parameter int WLOW_CYC  = 6,
    parameter int WHIGH_CYC = 5,
    parameter int OEH_CYC   = 2,
    parameter int ACC_CYC   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_write,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [7:0]        start_data,
    input  logic [CS_W-1:0]   start_cs,
    output logic              done,
    output logic [7:0]        rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_dq_out,
    output logic              bus_dq_oe,
    output logic              bus_we_n,
    output logic              bus_oe_n,
    output logic              bus_ce_act,
    output logic [CS_W-1:0]   bus_cs,
    input  logic [7:0]        bus_dq_in
);

    localparam int CNT_MAX = fcs_pkg::max2(fcs_pkg::max2(WLOW_CYC, WHIGH_CYC),
                                           fcs_pkg::max2(OEH_CYC, ACC_CYC));
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef enum logic [2:0] {
        E_IDLE, E_WSET, E_WLOW, E_WHIGH, E_RSET, E_RLOW
    } phase_e;

    phase_e           ph;
    logic [CNT_W-1:0] cnt;

    // Phase sequencing, strobe generation and read sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph         <= E_IDLE;
            cnt        <= '0;
            done       <= 1'b0;
            rdata      <= '0;
            bus_addr   <= '0;
            bus_dq_out <= '0;
            bus_dq_oe  <= 1'b0;
            bus_we_n   <= 1'b1;
            bus_oe_n   <= 1'b1;
            bus_ce_act <= 1'b0;
            bus_cs     <= '0;
        end else begin
            done <= 1'b0;
            case (ph)
                E_IDLE: begin
                    if (start) begin
                        bus_addr   <= start_addr;
                        bus_cs     <= start_cs;
                        bus_ce_act <= 1'b1;
                        if (start_write) begin
                            bus_dq_out <= start_data;
                            bus_dq_oe  <= 1'b1;
                            ph         <= E_WSET;
                        end else begin
                            cnt <= CNT_W'(OEH_CYC - 1);
                            ph  <= E_RSET;
                        end
                    end
                end
                E_WSET: begin
                    bus_we_n <= 1'b0;
                    cnt      <= CNT_W'(WLOW_CYC - 1);
                    ph       <= E_WLOW;
                end
                E_WLOW: begin
                    if (cnt == '0) begin
                        bus_we_n <= 1'b1;
                        cnt      <= CNT_W'(WHIGH_CYC - 1);
                        ph       <= E_WHIGH;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                E_WHIGH: begin
                    if (cnt == '0) begin
                        bus_ce_act <= 1'b0;
                        bus_dq_oe  <= 1'b0;
                        done       <= 1'b1;
                        ph         <= E_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                E_RSET: begin
                    if (cnt == '0) begin
                        bus_oe_n <= 1'b0;
                        cnt      <= CNT_W'(ACC_CYC - 1);
                        ph       <= E_RLOW;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                E_RLOW: begin
                    if (cnt == '0) begin
                        rdata      <= bus_dq_in;
                        bus_oe_n   <= 1'b1;
                        bus_ce_act <= 1'b0;
                        done       <= 1'b1;
                        ph         <= E_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: ph <= E_IDLE;
            endcase
        end
    end

    // Independent measure of the write-enable low width for checking.
    logic [15:0] wl_seen;
    always_ff @(posedge clk) begin
        if (!rst_n)         wl_seen <= '0;
        else if (!bus_we_n) wl_seen <= wl_seen + 1'b1;
        else                wl_seen <= '0;
    end

    a_r4_we_low_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_we_n) |-> (wl_seen >= 16'(WLOW_CYC)));
    a_r4_stable_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we_n |=> ($stable(bus_addr) && $stable(bus_dq_out)));
    a_r4_fall_when_driven: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_we_n) |-> (bus_dq_oe && bus_ce_act));
    a_r5_no_strobe_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe_n |-> bus_we_n);
    a_r5_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe_n |-> !bus_dq_oe);
    a_r9_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (ph == E_IDLE));

endmodule

// File: rtl/fcs_ctrl.sv
// Operation sequencer. Accepts one request, walks the unlock/command
// write list for program or erase, then polls the target until data
// bit 7 shows the final value or the poll budget runs out, in which case
// it sends the return-to-read command. Assumes one engine cycle at a time.
module fcs_ctrl #(
    parameter int ADDR_W     = 21,
    parameter int CS_W       = 2,
    parameter int POLL_LIMIT = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_off,
    input  logic [CS_W-1:0]   req_cs,
    input  logic [7:0]        req_wdata,
    output logic              eng_start,
    output logic              eng_write,
    output logic [ADDR_W-1:0] eng_addr,
    output logic [7:0]        eng_data,
    output logic [CS_W-1:0]   eng_cs,
    input  logic              eng_done,
    input  logic [7:0]        eng_rdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [7:0]        rsp_data
);
    import fcs_pkg::*;

    localparam int PW = $clog2(POLL_LIMIT + 1);

    typedef enum logic [2:0] { C_IDLE, C_CMD, C_POLL, C_RST, C_READ } cstate_e;

    cstate_e           st;
    fcs_op_e           op_q;
    logic [ADDR_W-1:0] off_q;
    logic [CS_W-1:0]   cs_q;
    logic [7:0]        wd_q;
    logic [2:0]        step_q;
    logic [PW-1:0]     polls_q;
    logic              launched_q;
    logic [ADDR_W-1:0] step_addr;
    logic [7:0]        step_data;
    logic [2:0]        last_step;
    logic              exp_b7;

    localparam logic [ADDR_W-1:0] A1 = ADDR_W'(KEY_ADDR1);
    localparam logic [ADDR_W-1:0] A2 = ADDR_W'(KEY_ADDR2);

    // Address/data of the current command step.
    always_comb begin
        step_addr = A1;
        step_data = CMD_KEY1;
        case (step_q)
            3'd0: begin step_addr = A1; step_data = CMD_KEY1; end
            3'd1: begin step_addr = A2; step_data = CMD_KEY2; end
            3'd2: begin
                step_addr = A1;
                step_data = (op_q == OP_PROG) ? CMD_PROGRAM : CMD_ERASE;
            end
            3'd3: begin
                if (op_q == OP_PROG) begin step_addr = off_q; step_data = wd_q; end
                else                 begin step_addr = A1;    step_data = CMD_KEY1; end
            end
            3'd4: begin step_addr = A2; step_data = CMD_KEY2; end
            default: begin
                if (op_q == OP_ERASE_CHIP) begin step_addr = A1;    step_data = CMD_WHOLE;  end
                else                       begin step_addr = off_q; step_data = CMD_SECTOR; end
            end
        endcase
    end

    // Engine request fields and completion criteria for the current state.
    always_comb begin
        last_step = (op_q == OP_PROG) ? 3'd3 : 3'd5;
        exp_b7    = (op_q == OP_PROG) ? wd_q[7] : 1'b1;
        req_ready = (st == C_IDLE);
        eng_start = (st != C_IDLE) && !launched_q;
        eng_write = (st == C_CMD) || (st == C_RST);
        eng_cs    = cs_q;
        eng_addr  = (st == C_CMD) ? step_addr : off_q;
        eng_data  = (st == C_CMD) ? step_data : CMD_TO_READ;
    end

    // Request acceptance, step/poll bookkeeping and response generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= C_IDLE;
            op_q       <= OP_READ;
            off_q      <= '0;
            cs_q       <= '0;
            wd_q       <= '0;
            step_q     <= '0;
            polls_q    <= '0;
            launched_q <= 1'b0;
            rsp_valid  <= 1'b0;
            rsp_err    <= 1'b0;
            rsp_data   <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (st == C_IDLE) begin
                if (req_valid) begin
                    op_q       <= fcs_op_e'(req_op);
                    off_q      <= req_off;
                    cs_q       <= req_cs;
                    wd_q       <= req_wdata;
                    step_q     <= '0;
                    polls_q    <= '0;
                    launched_q <= 1'b0;
                    st         <= (fcs_op_e'(req_op) == OP_READ) ? C_READ : C_CMD;
                end
            end else begin
                if (eng_start) launched_q <= 1'b1;
                if (eng_done) begin
                    launched_q <= 1'b0;
                    case (st)
                        C_CMD: begin
                            if (step_q == last_step) st <= C_POLL;
                            else                     step_q <= step_q + 1'b1;
                        end
                        C_POLL: begin
                            if (eng_rdata[7] == exp_b7) begin
                                rsp_valid <= 1'b1;
                                rsp_err   <= 1'b0;
                                rsp_data  <= eng_rdata;
                                st        <= C_IDLE;
                            end else if (polls_q == PW'(POLL_LIMIT - 1)) begin
                                rsp_data <= eng_rdata;
                                st       <= C_RST;
                            end else begin
                                polls_q <= polls_q + 1'b1;
                            end
                        end
                        C_RST: begin
                            rsp_valid <= 1'b1;
                            rsp_err   <= 1'b1;
                            st        <= C_IDLE;
                        end
                        default: begin
                            rsp_valid <= 1'b1;
                            rsp_err   <= 1'b0;
                            rsp_data  <= eng_rdata;
                            st        <= C_IDLE;
                        end
                    endcase
                end
            end
        end
    end

    a_r6_rsp_follows_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(eng_done));
    a_r9_ready_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_ready);
    a_r9_single_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    a_r7_poll_budget: assert property (@(posedge clk) disable iff (!rst_n)
        (st == C_RST) |-> (polls_q == PW'(POLL_LIMIT - 1)));

endmodule

// File: rtl/flash_cmd_seq.sv
// Top of the flash command sequencer. Converts picosecond timing
// minimums into clock counts, splits the request address into chip index
// and device offset, and joins the sequencer, the bus engine and the
// chip select decoder. Assumes ADDR_W >= 16 and an 8-bit data lane.
module flash_cmd_seq #(
    parameter int CLK_PS     = 8000,
    parameter int T_WP_PS    = 45000,
    parameter int T_WPH_PS   = 20000,
    parameter int T_WC_PS    = 90000,
    parameter int T_AH_PS    = 45000,
    parameter int T_DS_PS    = 45000,
    parameter int T_OEH_PS   = 10000,
    parameter int T_ACC_PS   = 90000,
    parameter int ADDR_W     = 21,
    parameter int NUM_CS     = 4,
    parameter int POLL_LIMIT = 4096,
    localparam int CS_W      = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int HA_W      = ADDR_W + CS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [HA_W-1:0]   req_addr,
    input  logic [7:0]        req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [7:0]        rsp_data,
    output logic [ADDR_W-1:0] flash_addr,
    input  logic [7:0]        flash_dq_in,
    output logic [7:0]        flash_dq_out,
    output logic              flash_dq_oe,
    output logic [NUM_CS-1:0] flash_ce_n,
    output logic              flash_oe_n,
    output logic              flash_we_n
);
    import fcs_pkg::*;

    localparam int WP_CYC    = ps_to_cyc(T_WP_PS, CLK_PS);
    localparam int WPH_CYC   = ps_to_cyc(T_WPH_PS, CLK_PS);
    localparam int WC_CYC    = ps_to_cyc(T_WC_PS, CLK_PS);
    localparam int AH_CYC    = ps_to_cyc(T_AH_PS, CLK_PS);
    localparam int DS_CYC    = ps_to_cyc(T_DS_PS, CLK_PS);
    localparam int OEH_CYC   = ps_to_cyc(T_OEH_PS, CLK_PS);
    localparam int ACC_CYC   = ps_to_cyc(T_ACC_PS, CLK_PS);
    localparam int WLOW_CYC  = max2(WP_CYC, max2(AH_CYC, DS_CYC));
    localparam int WHIGH_CYC = max2(WPH_CYC, max2(WC_CYC - 1 - WLOW_CYC, 1));

    logic              eng_start, eng_write, eng_done, ce_act;
    logic [ADDR_W-1:0] eng_addr;
    logic [7:0]        eng_data, eng_rdata;
    logic [CS_W-1:0]   eng_cs, bus_cs;

    fcs_ctrl #(
        .ADDR_W(ADDR_W), .CS_W(CS_W), .POLL_LIMIT(POLL_LIMIT)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_off(req_addr[ADDR_W-1:0]), .req_cs(req_addr[HA_W-1:ADDR_W]),
        .req_wdata(req_wdata),
        .eng_start(eng_start), .eng_write(eng_write), .eng_addr(eng_addr),
        .eng_data(eng_data), .eng_cs(eng_cs), .eng_done(eng_done),
        .eng_rdata(eng_rdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data)
    );

    fcs_bus_engine #(
        .ADDR_W(ADDR_W), .CS_W(CS_W), .WLOW_CYC(WLOW_CYC),
        .WHIGH_CYC(WHIGH_CYC), .OEH_CYC(OEH_CYC), .ACC_CYC(ACC_CYC)
    ) u_eng (
        .clk(clk), .rst_n(rst_n),
        .start(eng_start), .start_write(eng_write), .start_addr(eng_addr),
        .start_data(eng_data), .start_cs(eng_cs),
        .done(eng_done), .rdata(eng_rdata),
        .bus_addr(flash_addr), .bus_dq_out(flash_dq_out), .bus_dq_oe(flash_dq_oe),
        .bus_we_n(flash_we_n), .bus_oe_n(flash_oe_n), .bus_ce_act(ce_act),
        .bus_cs(bus_cs), .bus_dq_in(flash_dq_in)
    );

    fcs_cs_decode #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_dec (
        .active(ce_act), .sel(bus_cs), .ce_n(flash_ce_n)
    );

    a_r8_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~flash_ce_n));
    a_r8_idle_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (&flash_ce_n));
    a_r5_read_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_oe_n |-> ($countones(~flash_ce_n) == 1));

endmodule

// File: tb/flash_cmd_seq_test.sv
`timescale 1ns/1ps
module flash_cmd_seq_test;
    localparam int ADDR_W = 21;
    localparam int NUM_CS = 4;
    localparam int CS_W   = 2;
    localparam int HA_W   = ADDR_W + CS_W;
    localparam int PLIM   = 8;
    localparam int CLKPS  = 8000;
    localparam int E_WLOW = (45000 + CLKPS - 1) / CLKPS;
    localparam int E_WPH  = (20000 + CLKPS - 1) / CLKPS;
    localparam int E_WC   = (90000 + CLKPS - 1) / CLKPS;
    localparam int E_OEH  = (10000 + CLKPS - 1) / CLKPS;
    localparam int E_ACC  = (90000 + CLKPS - 1) / CLKPS;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_op = '0;
    logic [HA_W-1:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic req_ready, rsp_valid, rsp_err, flash_dq_oe, flash_oe_n, flash_we_n;
    logic [7:0] rsp_data, flash_dq_in, flash_dq_out;
    logic [ADDR_W-1:0] flash_addr;
    logic [NUM_CS-1:0] flash_ce_n;

    always #4 clk = ~clk;

    flash_cmd_seq #(.ADDR_W(ADDR_W), .NUM_CS(NUM_CS), .POLL_LIMIT(PLIM)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
        .flash_addr(flash_addr), .flash_dq_in(flash_dq_in),
        .flash_dq_out(flash_dq_out), .flash_dq_oe(flash_dq_oe),
        .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n), .flash_we_n(flash_we_n)
    );

    int checks = 0, errors = 0;
    bit finished = 0;

    // ---- device model: state written only by the bench task ----
    int m_busy = 0, m_rbase = 0;
    logic [7:0] m_busy_val = '0, m_final = '0;
    // ---- observations: written only by the monitor ----
    int w_total = 0, r_total = 0;
    logic [ADDR_W-1:0] w_addr [512];
    logic [7:0]        w_data [512];
    int                w_cs   [512];
    int                r_cs   [512];
    int v_r4 = 0, v_r5 = 0, v_r8 = 0;
    int wl_cnt = 0, wh_cnt = 100, ff_cnt = 100, oeh_cnt = 0, ol_cnt = 0;
    logic prev_we = 1'b1, prev_oe = 1'b1;

    assign flash_dq_in = (!flash_oe_n && !(&flash_ce_n)) ?
                         (((r_total - m_rbase) < m_busy) ? m_busy_val : m_final) : 8'h00;

    function automatic int sel_of(input logic [NUM_CS-1:0] ce);
        for (int i = 0; i < NUM_CS; i++) if (!ce[i]) return i;
        return -1;
    endfunction

    // Monitor: bus timing, command log and select checks, between edges.
    always @(negedge clk) begin
        if (rst_n) begin
            if ($countones(~flash_ce_n) > 1) v_r8++;
            if (!flash_oe_n && !flash_we_n) v_r5++;
            if (!flash_oe_n && flash_dq_oe) v_r5++;
            if (!flash_we_n && prev_we) begin
                if (wh_cnt < E_WPH || ff_cnt < E_WC) v_r4++;
                ff_cnt = 0;
            end
            if (flash_we_n && !prev_we) begin
                if (wl_cnt < E_WLOW) v_r4++;
                w_addr[w_total % 512] = flash_addr;
                w_data[w_total % 512] = flash_dq_out;
                w_cs[w_total % 512]   = sel_of(flash_ce_n);
                w_total++;
                wh_cnt = 0;
            end
            if (!flash_oe_n && prev_oe) begin
                if (oeh_cnt < E_OEH) v_r5++;
                r_cs[r_total % 512] = sel_of(flash_ce_n);
            end
            if (flash_oe_n && !prev_oe) begin
                if (ol_cnt < E_ACC) v_r5++;
                r_total++;
            end
            if (!flash_we_n) wl_cnt++; else begin wl_cnt = 0; wh_cnt++; end
            ff_cnt++;
            if (!flash_oe_n) ol_cnt++; else ol_cnt = 0;
            if (flash_oe_n && !(&flash_ce_n)) oeh_cnt++; else oeh_cnt = 0;
            prev_we = flash_we_n;
            prev_oe = flash_oe_n;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Expected command write k for an operation (R1, R2, R3, R7).
    function automatic logic [ADDR_W+7:0] exp_wr(input int op, input int k,
            input logic [ADDR_W-1:0] off, input logic [7:0] wd);
        int n = (op == 1) ? 4 : 6;
        if (k >= n) return {off, 8'hF0};
        case (k)
            0: return {ADDR_W'(16'h5555), 8'hAA};
            1: return {ADDR_W'(16'h2AAA), 8'h55};
            2: return {ADDR_W'(16'h5555), (op == 1) ? 8'hA0 : 8'h80};
            3: return (op == 1) ? {off, wd} : {ADDR_W'(16'h5555), 8'hAA};
            4: return {ADDR_W'(16'h2AAA), 8'h55};
            default: return (op == 3) ? {ADDR_W'(16'h5555), 8'h10} : {off, 8'h30};
        endcase
    endfunction

    task automatic run_req(input int op, input int sel, input logic [ADDR_W-1:0] off,
                           input logic [7:0] wd, input logic [7:0] rdv, input int busy);
        int wb, rb, nw, nr, cyc, v4, v5, v8, bad_cs;
        bit got, exp_err, e7;
        string rq;
        logic [7:0] exp_data, got_data;
        logic got_err;
        logic [ADDR_W+7:0] ew;
        rq = (op == 0) ? "R10" : (op == 1) ? "R1" : (op == 2) ? "R2" : "R3";
        e7 = (op == 1) ? wd[7] : 1'b1;
        m_busy     = (op == 0) ? 0 : busy;
        m_busy_val = {~e7, 7'($urandom)};
        m_final    = (op == 0) ? rdv : (op == 1) ? wd : 8'hFF;
        m_rbase    = r_total;
        wb = w_total; rb = r_total; v4 = v_r4; v5 = v_r5; v8 = v_r8;
        cyc = 0;
        while (!req_ready && cyc < 5000) begin @(negedge clk); cyc++; end
        req_op = 2'(op); req_addr = {CS_W'(sel), off}; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        got = 0; got_err = 0; got_data = 0; cyc = 0;
        while (!got && cyc < 20000) begin
            if (rsp_valid) begin got = 1; got_err = rsp_err; got_data = rsp_data; end
            else begin @(negedge clk); cyc++; end
        end
        check(got, "R9", "response seen", got, 1);
        exp_err  = (op != 0) && (busy >= PLIM);
        exp_data = (op == 0) ? rdv : exp_err ? m_busy_val : m_final;
        nw = (op == 0) ? 0 : ((op == 1) ? 4 : 6) + (exp_err ? 1 : 0);
        nr = (op == 0) ? 1 : (exp_err ? PLIM : busy + 1);
        check(got_err == exp_err, exp_err ? "R7" : "R6", "error flag", got_err, exp_err);
        check(got_data == exp_data, (op == 0) ? "R10" : "R6", "response data", got_data, exp_data);
        check(w_total - wb == nw, rq, "write count", w_total - wb, nw);
        check(r_total - rb == nr, exp_err ? "R7" : "R6", "poll read count", r_total - rb, nr);
        bad_cs = 0;
        for (int k = 0; k < nw && k < w_total - wb; k++) begin
            ew = exp_wr(op, k, off, wd);
            check({w_addr[(wb + k) % 512], w_data[(wb + k) % 512]} == ew,
                  (k >= nw - 1 && exp_err) ? "R7" : rq, "write addr/data",
                  {w_addr[(wb + k) % 512], w_data[(wb + k) % 512]}, ew);
            if (w_cs[(wb + k) % 512] != sel) bad_cs++;
        end
        for (int k = 0; k < r_total - rb; k++) if (r_cs[(rb + k) % 512] != sel) bad_cs++;
        check(bad_cs == 0, "R8", "cycles on wrong select", bad_cs, 0);
        check(v_r4 == v4, "R4", "write timing violations", v_r4 - v4, 0);
        check(v_r5 == v5, "R5", "read timing violations", v_r5 - v5, 0);
        check(v_r8 == v8, "R8", "overlapping selects", v_r8 - v8, 0);
        @(negedge clk);
        check(req_ready && !rsp_valid, "R9", "ready, single pulse", {req_ready, rsp_valid}, 2'b10);
        check(&flash_ce_n, "R8", "idle selects", flash_ce_n, 4'hF);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1F1A5));
        repeat (4) @(negedge clk);
        // R9 reset state, still in reset.
        check(req_ready && !rsp_valid && !flash_dq_oe && flash_oe_n && flash_we_n && (&flash_ce_n),
              "R9", "reset state",
              {req_ready, rsp_valid, flash_dq_oe, flash_oe_n, flash_we_n, flash_ce_n},
              {3'b100, 2'b11, 4'hF});
        rst_n = 1'b1;
        @(negedge clk);
        // Directed corners.
        for (int s = 0; s < NUM_CS; s++) run_req(0, s, ADDR_W'(21'h1234 + s), 8'h00, 8'hC3 ^ 8'(s), 0);
        run_req(1, 0, 21'h0ABCD, 8'h80, 8'h00, 0);          // R1/R6 immediate match, bit7=1
        run_req(1, 1, 21'h1FFFF, 8'h35, 8'h00, 3);          // R6 bit7=0 target, busy 3
        run_req(2, 2, 21'h130000, 8'h00, 8'h00, 2);         // R2
        run_req(3, 3, 21'h000000, 8'h00, 8'h00, 5);         // R3
        run_req(1, 2, 21'h00555, 8'h7E, 8'h00, PLIM - 1);   // R6 match on last read
        run_req(2, 1, 21'h0F000, 8'h00, 8'h00, PLIM);       // R7 timeout boundary
        run_req(1, 3, 21'h10001, 8'h01, 8'h00, PLIM + 3);   // R7 program timeout
        for (int i = 0; i < 30; i++)
            run_req($urandom_range(0, 3), $urandom_range(0, NUM_CS - 1),
                    ADDR_W'($urandom), 8'($urandom), 8'($urandom), $urandom_range(0, PLIM + 1));
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule